// File: doc/BRIEF.md
# Load-Use Stall Scoreboard

This block sits beside the issue stage of an in-order core and works out how many stall cycles each issued instruction costs. For every instruction it is given the unit class, up to two source register numbers with their own valid flags, a destination register and a branch-taken flag. A load marks its destination as pending. The next accepted instruction is charged a fixed penalty for every checked source that names a pending register. A taken control transfer costs its own fixed penalty. The block does not hold the pipeline and does not predict branches. It only reports the cost.

Instructions arrive on a valid/ready input. The block never applies back-pressure: `in_ready` is held high, and every cycle with `in_valid` high accepts one instruction. Each accepted instruction produces a one-cycle `res_valid` pulse on the next clock, with its cost on `res_cycles`. The result output has no ready. Four running totals (load stall cycles, branch stall cycles, taken transfers and untaken transfers) are plain outputs that saturate.

Top module: `ldstall_scoreboard`

## Requirements
- R1: A synchronous reset clears the pending mask, all four totals, `res_valid` and `res_cycles`.
- R2: `in_ready` is always 1. `res_valid` is high in the cycle after an accepted instruction and low otherwise. Cycles with `in_valid` low change neither the totals nor the pending mask.
- R3: A load (unit code 4) makes its destination register pending for the next accepted instruction only. Each accepted instruction replaces the pending mask, and idle cycles do not count as instructions.
- R4: Exec, compare and multiply-accumulate (unit codes 0, 1, 2) check both sources. Each source that hits a pending register adds 2 cycles, so up to 4 cycles in total.
- R5: A control transfer (unit code 3) checks only source 0. Source 1 is ignored even when it is valid and pending.
- R6: A source whose valid flag is 0 never hits.
- R7: A taken control transfer adds 2 cycles, adds 2 to the branch stall total and adds 1 to the taken count. An untaken one adds 1 to the untaken count and nothing else.
- R8: Loads, stores (code 5) and the reserved codes 6 and 7 cost 0 cycles and check no sources. Stores and reserved codes leave the next pending mask empty.
- R9: The load stall total grows by the source-hit cycles of each accepted instruction.
- R10: Every total is CNT_W bits wide (32 by default) and sticks at all ones instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Always 1 |
| in_unit | input | 3 | Unit class code |
| in_src0 | input | 4 | Source 0 register number |
| in_src0_vld | input | 1 | Source 0 is used |
| in_src1 | input | 4 | Source 1 register number |
| in_src1_vld | input | 1 | Source 1 is used |
| in_dst | input | 4 | Destination register |
| in_taken | input | 1 | Control transfer was taken |
| res_valid | output | 1 | Cost of the previous accepted instruction is valid |
| res_cycles | output | 3 | Stall cycles for that instruction |
| load_stall_total | output | CNT_W | Accumulated load-hazard cycles |
| branch_stall_total | output | CNT_W | Accumulated taken-transfer cycles |
| taken_count | output | CNT_W | Taken control transfers |
| untaken_count | output | CNT_W | Untaken control transfers |

## Verification
The bench targets several failure modes:
- A load followed by a non-load must see an empty mask. A mask that accumulates instead of being replaced would charge phantom stalls two instructions later.
- A control transfer with a pending source 1 must stay free. A design that checks both sources for control transfers would charge 2 cycles there.
- A source flagged invalid must never hit. Ignoring the flag would make a register 6 that is not used cost cycles.
- The mask must survive idle gaps. Treating idle cycles as instruction boundaries would lose the hazard.
- A narrow counter build is driven past its maximum. A wrapping counter would drop back to small values.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [2:0] {
    U_EXEC  = 3'd0,
    U_CMP   = 3'd1,
    U_MAC   = 3'd2,
    U_CTI   = 3'd3,
    U_LOAD  = 3'd4,
    U_STORE = 3'd5,
    U_RSV6  = 3'd6,
    U_RSV7  = 3'd7
  } unit_e;

  // which operand slots a unit class reads for hazard purposes
  function automatic logic reads_src0(unit_e u);
    return (u == U_EXEC) || (u == U_CMP) || (u == U_MAC) || (u == U_CTI);
  endfunction

  function automatic logic reads_src1(unit_e u);
    return (u == U_EXEC) || (u == U_CMP) || (u == U_MAC);
  endfunction
endpackage

// File: rtl/sb_src_check.sv
module sb_src_check #(
  parameter int NREG = 16,
  localparam int RW = $clog2(NREG)
) (
  input  logic            slot_en,
  input  logic            src_vld,
  input  logic [RW-1:0]   src_idx,
  input  logic [NREG-1:0] pend_mask,
  output logic            hit
);
  always_comb begin
    hit = slot_en && src_vld && pend_mask[src_idx];
  end
endmodule

// File: rtl/sb_sat_ctr.sv
module sb_sat_ctr #(
  parameter int W     = 32,
  parameter int AMT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_en,
  input  logic [AMT_W-1:0] inc_amt,
  output logic [W-1:0]     q
);
  localparam logic [W:0] MAXV = {1'b0, {W{1'b1}}};

  logic [W:0] sum;

  always_comb begin
    sum = {1'b0, q} + (W+1)'(inc_amt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (inc_en) begin
      q <= (sum > MAXV) ? {W{1'b1}} : sum[W-1:0];
    end
  end

  // totals never wrap back to a smaller value
  assert_no_wrap_R10: assert property (@(posedge clk) disable iff (rst)
    inc_en |=> q >= $past(q));

  // no increment, no movement
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !inc_en |=> $stable(q));
endmodule

// File: rtl/ldstall_scoreboard.sv
module ldstall_scoreboard #(
  parameter int NREG   = 16,
  parameter int CNT_W  = 32,
  parameter int LD_PEN = 2,
  parameter int BR_PEN = 2,
  localparam int RW    = $clog2(NREG),
  localparam int CW    = $clog2(2*LD_PEN + BR_PEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_unit,
  input  logic [RW-1:0]    in_src0,
  input  logic             in_src0_vld,
  input  logic [RW-1:0]    in_src1,
  input  logic             in_src1_vld,
  input  logic [RW-1:0]    in_dst,
  input  logic             in_taken,
  output logic             res_valid,
  output logic [CW-1:0]    res_cycles,
  output logic [CNT_W-1:0] load_stall_total,
  output logic [CNT_W-1:0] branch_stall_total,
  output logic [CNT_W-1:0] taken_count,
  output logic [CNT_W-1:0] untaken_count
);
  import sb_pkg::*;

  localparam int NSRC = 2;

  unit_e           ucls;
  logic            accept;
  logic [NREG-1:0] hazard_mask;
  logic [NSRC-1:0] slot_en, slot_vld, slot_hit;
  logic [RW-1:0]   slot_idx [NSRC];
  logic [CW-1:0]   ld_cyc, br_cyc;
  logic            is_taken, is_untaken;

  assign in_ready = 1'b1;
  assign accept   = in_valid;
  assign ucls     = unit_e'(in_unit);

  assign slot_en[0]  = reads_src0(ucls);
  assign slot_en[1]  = reads_src1(ucls);
  assign slot_vld[0] = in_src0_vld;
  assign slot_vld[1] = in_src1_vld;
  assign slot_idx[0] = in_src0;
  assign slot_idx[1] = in_src1;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    sb_src_check #(.NREG(NREG)) chk_i (
      .slot_en  (slot_en[g]),
      .src_vld  (slot_vld[g]),
      .src_idx  (slot_idx[g]),
      .pend_mask(hazard_mask),
      .hit      (slot_hit[g])
    );
  end

  always_comb begin
    ld_cyc = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (slot_hit[i]) ld_cyc = ld_cyc + CW'(LD_PEN);
    end
    is_taken   = (ucls == U_CTI) && in_taken;
    is_untaken = (ucls == U_CTI) && !in_taken;
    br_cyc     = is_taken ? CW'(BR_PEN) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hazard_mask <= '0;
      res_valid   <= 1'b0;
      res_cycles  <= '0;
    end else begin
      res_valid <= accept;
      if (accept) begin
        res_cycles  <= ld_cyc + br_cyc;
        hazard_mask <= (ucls == U_LOAD) ? (NREG'(1) << in_dst) : '0;
      end
    end
  end

  sb_sat_ctr #(.W(CNT_W), .AMT_W(CW)) ld_tot_i (
    .clk(clk), .rst(rst), .inc_en(accept), .inc_amt(ld_cyc), .q(load_stall_total));

  sb_sat_ctr #(.W(CNT_W), .AMT_W(CW)) br_tot_i (
    .clk(clk), .rst(rst), .inc_en(accept && is_taken), .inc_amt(CW'(BR_PEN)),
    .q(branch_stall_total));

  sb_sat_ctr #(.W(CNT_W), .AMT_W(CW)) tk_cnt_i (
    .clk(clk), .rst(rst), .inc_en(accept && is_taken), .inc_amt(CW'(1)),
    .q(taken_count));

  sb_sat_ctr #(.W(CNT_W), .AMT_W(CW)) ut_cnt_i (
    .clk(clk), .rst(rst), .inc_en(accept && is_untaken), .inc_amt(CW'(1)),
    .q(untaken_count));

  // a non-load instruction leaves nothing pending for its successor
  assert_mask_replace_R3: assert property (@(posedge clk) disable iff (rst)
    (accept && ucls != U_LOAD) |=> hazard_mask == '0);

  // result strobe follows acceptance by exactly one cycle
  assert_res_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !res_valid);

  // loads, stores and reserved codes are free
  assert_free_units_R8: assert property (@(posedge clk) disable iff (rst)
    (accept && in_unit >= 3'd4) |=> res_cycles == '0);

  // an untaken transfer never touches the branch stall total
  assert_untaken_nostall_R7: assert property (@(posedge clk) disable iff (rst)
    (accept && is_untaken) |=> $stable(branch_stall_total));

  // an idle cycle keeps the pending registers
  assert_idle_keep_R3: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(hazard_mask));
endmodule

// File: tb/ldstall_scoreboard_tb_top.sv
module ldstall_scoreboard_tb_top;
  localparam int CNT_W = 5;
  localparam int MAXC  = (1 << CNT_W) - 1;
  localparam int NV    = 21;

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_ready;
  logic [2:0] in_unit = 0;
  logic [3:0] in_src0 = 0, in_src1 = 0, in_dst = 0;
  logic in_src0_vld = 0, in_src1_vld = 0, in_taken = 0;
  logic res_valid;
  logic [2:0] res_cycles;
  logic [CNT_W-1:0] load_stall_total, branch_stall_total, taken_count, untaken_count;

  int n_chk = 0, n_fail = 0;
  int e_ld = 0, e_br = 0, e_tk = 0, e_ut = 0;

  always #5 clk = ~clk;

  ldstall_scoreboard #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_unit(in_unit), .in_src0(in_src0), .in_src0_vld(in_src0_vld),
    .in_src1(in_src1), .in_src1_vld(in_src1_vld), .in_dst(in_dst),
    .in_taken(in_taken), .res_valid(res_valid), .res_cycles(res_cycles),
    .load_stall_total(load_stall_total), .branch_stall_total(branch_stall_total),
    .taken_count(taken_count), .untaken_count(untaken_count));

  // {unit, src0, v0, src1, v1, dst, taken, expected cycles}
  localparam logic [20:0] VEC [NV] = '{
    {3'd4, 4'd0, 1'b0, 4'd0, 1'b0, 4'd3, 1'b0, 3'd0},  // load r3
    {3'd0, 4'd3, 1'b1, 4'd5, 1'b1, 4'd0, 1'b0, 3'd2},  // R4 exec hits r3
    {3'd0, 4'd3, 1'b1, 4'd0, 1'b0, 4'd0, 1'b0, 3'd0},  // R3 mask replaced
    {3'd4, 4'd0, 1'b0, 4'd0, 1'b0, 4'd7, 1'b0, 3'd0},  // load r7
    {3'd4, 4'd7, 1'b1, 4'd0, 1'b0, 4'd8, 1'b0, 3'd0},  // R8 load checks nothing
    {3'd1, 4'd8, 1'b1, 4'd8, 1'b1, 4'd0, 1'b0, 3'd4},  // R4 cmp both hit
    {3'd4, 4'd0, 1'b0, 4'd0, 1'b0, 4'd2, 1'b0, 3'd0},  // load r2
    {3'd2, 4'd1, 1'b1, 4'd2, 1'b1, 4'd0, 1'b0, 3'd2},  // R4 mac src1 hits
    {3'd4, 4'd0, 1'b0, 4'd0, 1'b0, 4'd4, 1'b0, 3'd0},  // load r4
    {3'd3, 4'd5, 1'b1, 4'd4, 1'b1, 4'd0, 1'b0, 3'd0},  // R5 cti ignores src1
    {3'd4, 4'd0, 1'b0, 4'd0, 1'b0, 4'd4, 1'b0, 3'd0},  // load r4
    {3'd3, 4'd4, 1'b1, 4'd0, 1'b0, 4'd0, 1'b1, 3'd4},  // R7 taken plus hit
    {3'd4, 4'd0, 1'b0, 4'd0, 1'b0, 4'd6, 1'b0, 3'd0},  // load r6
    {3'd0, 4'd6, 1'b0, 4'd6, 1'b0, 4'd0, 1'b0, 3'd0},  // R6 invalid sources
    {3'd4, 4'd0, 1'b0, 4'd0, 1'b0, 4'd9, 1'b0, 3'd0},  // load r9
    {3'd5, 4'd9, 1'b1, 4'd9, 1'b1, 4'd0, 1'b0, 3'd0},  // R8 store free
    {3'd0, 4'd9, 1'b1, 4'd0, 1'b0, 4'd0, 1'b0, 3'd0},  // R8 store emptied mask
    {3'd3, 4'd0, 1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 3'd2},  // R7 taken, no hazard
    {3'd4, 4'd0, 1'b0, 4'd0, 1'b0, 4'd1, 1'b0, 3'd0},  // load r1
    {3'd7, 4'd1, 1'b1, 4'd0, 1'b0, 4'd0, 1'b0, 3'd0},  // R8 reserved free
    {3'd0, 4'd1, 1'b1, 4'd0, 1'b0, 4'd0, 1'b0, 3'd0}   // R8 reserved emptied mask
  };

  function automatic int sat(int x);
    return (x > MAXC) ? MAXC : x;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic issue(logic [2:0] u, logic [3:0] s0, logic v0, logic [3:0] s1,
                       logic v1, logic [3:0] d, logic tk);
    in_unit = u; in_src0 = s0; in_src0_vld = v0; in_src1 = s1;
    in_src1_vld = v1; in_dst = d; in_taken = tk; in_valid = 1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic model(logic [2:0] u, logic tk, int cyc);
    int br;
    br = (u == 3'd3 && tk) ? 2 : 0;
    e_ld = sat(e_ld + cyc - br);
    if (u == 3'd3 && tk) begin e_br = sat(e_br + 2); e_tk = sat(e_tk + 1); end
    if (u == 3'd3 && !tk) e_ut = sat(e_ut + 1);
  endtask

  task automatic chk_totals(string req);
    chk({req, " load total"}, int'(load_stall_total), e_ld);
    chk({req, " branch total"}, int'(branch_stall_total), e_br);
    chk({req, " taken"}, int'(taken_count), e_tk);
    chk({req, " untaken"}, int'(untaken_count), e_ut);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 res_valid", int'(res_valid), 0);
    chk("R1 res_cycles", int'(res_cycles), 0);
    chk_totals("R1");
    chk("R2 in_ready", int'(in_ready), 1);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][20:18], VEC[i][17:14], VEC[i][13], VEC[i][12:9], VEC[i][8],
            VEC[i][7:4], VEC[i][3]);
      chk("R2 res_valid", int'(res_valid), 1);
      chk($sformatf("R4/R5/R6/R7/R8 vector %0d cycles", i), int'(res_cycles),
          int'(VEC[i][2:0]));
      model(VEC[i][20:18], VEC[i][3], int'(VEC[i][2:0]));
    end
    chk_totals("R9 R7 after table");

    // R3: the mask survives idle gaps
    issue(3'd4, 4'd0, 1'b0, 4'd0, 1'b0, 4'd3, 1'b0);
    repeat (3) @(negedge clk);
    chk("R2 idle res_valid", int'(res_valid), 0);
    chk_totals("R2 idle");
    issue(3'd0, 4'd3, 1'b1, 4'd0, 1'b0, 4'd0, 1'b0);
    chk("R3 hazard across idle", int'(res_cycles), 2);
    model(3'd0, 1'b0, 2);
    chk_totals("R9 after idle");

    // R10 saturation
    for (int k = 0; k < 30; k++) begin
      issue(3'd3, 4'd0, 1'b0, 4'd0, 1'b0, 4'd0, 1'b1);
      model(3'd3, 1'b1, 2);
    end
    for (int k = 0; k < 40; k++) begin
      issue(3'd3, 4'd0, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0);
      model(3'd3, 1'b0, 0);
    end
    for (int k = 0; k < 10; k++) begin
      issue(3'd4, 4'd0, 1'b0, 4'd0, 1'b0, 4'd5, 1'b0);
      issue(3'd1, 4'd5, 1'b1, 4'd0, 1'b0, 4'd0, 1'b0);
      model(3'd1, 1'b0, 2);
    end
    chk("R10 branch total sticks", int'(branch_stall_total), MAXC);
    chk("R10 taken sticks", int'(taken_count), MAXC);
    chk("R10 untaken sticks", int'(untaken_count), MAXC);
    chk_totals("R10");

    // R1 reset clears the pending mask and totals
    issue(3'd4, 4'd0, 1'b0, 4'd0, 1'b0, 4'd3, 1'b0);
    rst = 1;
    @(negedge clk);
    rst = 0;
    e_ld = 0; e_br = 0; e_tk = 0; e_ut = 0;
    chk("R1 res_valid after reset", int'(res_valid), 0);
    chk_totals("R1 after reset");
    issue(3'd0, 4'd3, 1'b1, 4'd0, 1'b0, 4'd0, 1'b0);
    chk("R1 mask cleared", int'(res_cycles), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule